// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block keeps the nine status flags of an I2C controller. The bus engine reports events as single-cycle pulses: a misplaced start or stop, a detected STOP, a NACK after a sent byte, an own-address match, a byte landing in the receive data register, the transmit data register running empty, and the programmed byte count being reached. Register-bus activity arrives as strobes: a write to the flag clear register, a write to the transmit data register, a read of the receive data register, a rewrite of the byte count, a software START/STOP request, and a write to the status register itself.

Each flag has its own set condition, qualified by the operating mode and configuration, and its own clear path. When the peripheral enable is low, every flag is held low except transmit-empty, which is held high. The flags are packed into an 11-bit status word. A registered interrupt line and a registered transmit DMA request are derived from the flags.

Top module: `i2c_status_unit`

## Requirements
- R1: Reset, and any cycle with `en` low, leave the status word at 11'h001 on the next cycle: only transmit-empty (bit 0) is high. Events are ignored while disabled. Bits 10 and 9 always read 0.
- R2: Bus error (bit 8) sets on `ev_misplaced` when `in_xfer` is high, except in slave mode (`is_master` low) while `addr_phase` is high. It clears on a clear-register write with `clr_data[8]` high.
- R3: Reload-complete (bit 7) sets on `ev_cnt_done` when `cfg_reload` is high and either `is_master` or `cfg_sbc` is high. It clears on `cnt_wr` with a nonzero `cnt_val`. A zero count write leaves it unchanged.
- R4: Transfer-complete (bit 6) sets on `ev_cnt_done` only when `is_master` is high and both `cfg_reload` and `cfg_autoend` are low. It clears on `ctl_startstop_wr`.
- R5: Stop (bit 5) sets on `ev_stop` as master only when `stop_own` is high, and as slave only when an address match was seen in an earlier cycle since the last STOP. It clears through `clr_data[5]`.
- R6: NACK (bit 4) sets on `ev_nack` and clears through `clr_data[4]`. Address match (bit 3) sets on `ev_addr_match` and clears through `clr_data[3]`.
- R7: Receive-not-empty (bit 2) sets on `ev_rx_byte` and clears on `rxd_rd`.
- R8: Transmit-interrupt (bit 1) sets on `ev_tx_empty`, or on `sts_wr` with `sts_data[1]` high while `cfg_nostretch` is high. The latter write is ignored when `cfg_nostretch` is low. The flag clears on `txd_wr`.
- R9: Transmit-empty (bit 0) sets on `ev_tx_empty` or on `sts_wr` with `sts_data[0]` high (flush). It clears on `txd_wr`.
- R10: When a set condition and a clear for the same flag fall in the same cycle, the flag ends high.
- R11: `irq` is the OR of `status[i] & irq_mask[i]` over bits 8..0, registered one cycle after the flags. `tx_dma_req` is `status[1] & tx_dma_en`, registered the same way.
- R12: Flags change on the clock edge that samples their event, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Peripheral enable |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_reload | input | 1 | Byte-count reload mode |
| cfg_autoend | input | 1 | Automatic STOP after count |
| cfg_nostretch | input | 1 | Clock stretching disabled |
| cfg_sbc | input | 1 | Slave byte control enabled |
| in_xfer | input | 1 | Peripheral is taking part in a transfer |
| addr_phase | input | 1 | Bus is in the address phase |
| ev_misplaced | input | 1 | Misplaced start/stop pulse |
| ev_stop | input | 1 | STOP detected pulse |
| stop_own | input | 1 | The STOP was generated by this peripheral |
| ev_nack | input | 1 | NACK after a transmitted byte |
| ev_addr_match | input | 1 | Own address matched |
| ev_rx_byte | input | 1 | Byte copied to receive data register |
| ev_tx_empty | input | 1 | Transmit data register empty |
| ev_cnt_done | input | 1 | Programmed byte count reached |
| clr_wr | input | 1 | Clear register write strobe |
| clr_data | input | 9 | Clear register write data, bit i clears flag i |
| txd_wr | input | 1 | Transmit data register write |
| rxd_rd | input | 1 | Receive data register read |
| cnt_wr | input | 1 | Byte count field write |
| cnt_val | input | CNT_W | Byte count value written |
| ctl_startstop_wr | input | 1 | Software sets START or STOP |
| sts_wr | input | 1 | Status register write strobe |
| sts_data | input | 2 | Status write data: bit 1 transmit-interrupt, bit 0 flush |
| irq_mask | input | 9 | Per-flag interrupt enables |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| status | output | 11 | Status word |
| irq | output | 1 | Registered interrupt request |
| tx_dma_req | output | 1 | Registered transmit DMA request |

## Verification
Directed patterns first take each flag through its qualified and unqualified set conditions. These include slave address phase against data phase, reload with and without slave byte control, a zero against a nonzero count rewrite, no-stretch on and off, and a slave STOP before and after an address match. Together they separate a correct mode gate from a missing or inverted one. Simultaneous set and clear pulses distinguish set priority from clear priority. A long pseudo-random sweep then drives every event, strobe and configuration bit together, with the enable dropping now and then. This exposes interactions between clear paths and the disable override, and each output is compared against an arithmetic model of the requirements.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int NFLAG  = 9;
  localparam int STAT_W = 11;
  localparam int B_TXE  = 0;
  localparam int B_TXIS = 1;
  localparam int B_RXNE = 2;
  localparam int B_ADDR = 3;
  localparam int B_NACK = 4;
  localparam int B_STOP = 5;
  localparam int B_TC   = 6;
  localparam int B_TCR  = 7;
  localparam int B_BERR = 8;
endpackage

// File: rtl/i2cst_flag_cell.sv
module i2cst_flag_cell #(
  parameter bit IDLE_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || !en) q <= IDLE_VAL;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/i2cst_evt_decode.sv
module i2cst_evt_decode
  import i2cst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             is_master,
  input  logic             cfg_reload,
  input  logic             cfg_autoend,
  input  logic             cfg_nostretch,
  input  logic             cfg_sbc,
  input  logic             in_xfer,
  input  logic             addr_phase,
  input  logic             ev_misplaced,
  input  logic             ev_stop,
  input  logic             stop_own,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  input  logic             ev_rx_byte,
  input  logic             ev_tx_empty,
  input  logic             ev_cnt_done,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_data,
  input  logic             txd_wr,
  input  logic             rxd_rd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             ctl_startstop_wr,
  input  logic             sts_wr,
  input  logic [1:0]       sts_data,
  output logic [NFLAG-1:0] set_vec,
  output logic [NFLAG-1:0] clr_vec
);
  logic addressed_q;
  logic unused_clr;

  // Slave addressed tracking for the stop qualifier
  always_ff @(posedge clk) begin
    if (rst || !en) addressed_q <= 1'b0;
    else if (ev_stop) addressed_q <= 1'b0;
    else if (ev_addr_match && !is_master) addressed_q <= 1'b1;
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[B_BERR] = ev_misplaced && in_xfer && !(!is_master && addr_phase);
    set_vec[B_TCR]  = ev_cnt_done && cfg_reload && (is_master || cfg_sbc);
    set_vec[B_TC]   = ev_cnt_done && is_master && !cfg_reload && !cfg_autoend;
    set_vec[B_STOP] = ev_stop && (is_master ? stop_own : addressed_q);
    set_vec[B_NACK] = ev_nack;
    set_vec[B_ADDR] = ev_addr_match;
    set_vec[B_RXNE] = ev_rx_byte;
    set_vec[B_TXIS] = ev_tx_empty || (sts_wr && sts_data[1] && cfg_nostretch);
    set_vec[B_TXE]  = ev_tx_empty || (sts_wr && sts_data[0]);

    clr_vec[B_BERR] = clr_wr && clr_data[B_BERR];
    clr_vec[B_TCR]  = cnt_wr && (cnt_val != '0);
    clr_vec[B_TC]   = ctl_startstop_wr;
    clr_vec[B_STOP] = clr_wr && clr_data[B_STOP];
    clr_vec[B_NACK] = clr_wr && clr_data[B_NACK];
    clr_vec[B_ADDR] = clr_wr && clr_data[B_ADDR];
    clr_vec[B_RXNE] = rxd_rd;
    clr_vec[B_TXIS] = txd_wr;
    clr_vec[B_TXE]  = txd_wr;
  end

  assign unused_clr = ^{clr_data[B_TCR], clr_data[B_TC], clr_data[B_RXNE],
                        clr_data[B_TXIS], clr_data[B_TXE]};

  AST_STOP_SLAVE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (set_vec[B_STOP] && !is_master) |-> $past(ev_addr_match) || addressed_q) // R5
    else $error("stop flag set for unaddressed slave");
endmodule

// File: rtl/i2cst_req_gen.sv
module i2cst_req_gen
  import i2cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] irq_mask,
  input  logic             tx_dma_en,
  output logic             irq,
  output logic             tx_dma_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      irq        <= |(flags & irq_mask);
      tx_dma_req <= flags[B_TXIS] && tx_dma_en;
    end
  end

  AST_DMA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> $past(tx_dma_en)) // R11
    else $error("dma request without enable");
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
  import i2cst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              is_master,
  input  logic              cfg_reload,
  input  logic              cfg_autoend,
  input  logic              cfg_nostretch,
  input  logic              cfg_sbc,
  input  logic              in_xfer,
  input  logic              addr_phase,
  input  logic              ev_misplaced,
  input  logic              ev_stop,
  input  logic              stop_own,
  input  logic              ev_nack,
  input  logic              ev_addr_match,
  input  logic              ev_rx_byte,
  input  logic              ev_tx_empty,
  input  logic              ev_cnt_done,
  input  logic              clr_wr,
  input  logic [8:0]        clr_data,
  input  logic              txd_wr,
  input  logic              rxd_rd,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ctl_startstop_wr,
  input  logic              sts_wr,
  input  logic [1:0]        sts_data,
  input  logic [8:0]        irq_mask,
  input  logic              tx_dma_en,
  output logic [10:0]       status,
  output logic              irq,
  output logic              tx_dma_req
);
  logic [NFLAG-1:0] set_vec, clr_vec, flags;

  i2cst_evt_decode #(.CNT_W(CNT_W)) u_dec (
    .clk, .rst, .en, .is_master, .cfg_reload, .cfg_autoend, .cfg_nostretch,
    .cfg_sbc, .in_xfer, .addr_phase, .ev_misplaced, .ev_stop, .stop_own,
    .ev_nack, .ev_addr_match, .ev_rx_byte, .ev_tx_empty, .ev_cnt_done,
    .clr_wr, .clr_data, .txd_wr, .rxd_rd, .cnt_wr, .cnt_val,
    .ctl_startstop_wr, .sts_wr, .sts_data, .set_vec, .clr_vec
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    i2cst_flag_cell #(.IDLE_VAL(i == B_TXE)) u_cell (
      .clk, .rst, .en, .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q(flags[i])
    );
  end

  assign status = {{(STAT_W-NFLAG){1'b0}}, flags};

  i2cst_req_gen u_req (
    .clk, .rst, .flags, .irq_mask, .tx_dma_en, .irq, .tx_dma_req
  );

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> status == 11'h001) // R1
    else $error("disabled state wrong");
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en && ev_nack && clr_wr && clr_data[B_NACK]) |=> status[B_NACK]) // R10
    else $error("clear beat set");
  AST_RX_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (en && ev_rx_byte) |=> status[B_RXNE]) // R7
    else $error("rx flag missed");
  AST_TC_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (en && ev_cnt_done && !is_master && !status[B_TC]) |=> !status[B_TC]) // R4
    else $error("tc set in slave mode");
  AST_TXIS_STRETCH_GUARD: assert property (@(posedge clk) disable iff (rst)
    (en && sts_wr && !cfg_nostretch && !ev_tx_empty && !status[B_TXIS])
      |=> !status[B_TXIS]) // R8
    else $error("txis written while stretching");
endmodule

// File: tb/i2c_status_unit_test.sv
module i2c_status_unit_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, is_master, cfg_reload, cfg_autoend, cfg_nostretch, cfg_sbc;
  logic in_xfer, addr_phase, ev_misplaced, ev_stop, stop_own, ev_nack;
  logic ev_addr_match, ev_rx_byte, ev_tx_empty, ev_cnt_done, clr_wr;
  logic [8:0] clr_data, irq_mask;
  logic txd_wr, rxd_rd, cnt_wr, ctl_startstop_wr, sts_wr, tx_dma_en;
  logic [7:0] cnt_val;
  logic [1:0] sts_data;
  logic [10:0] status;
  logic irq, tx_dma_req;

  i2c_status_unit uut (.*);

  int nvec = 0, nbad = 0, cyc = 0;
  logic [8:0] ef = 9'h001;
  logic e_addr = 1'b0, e_irq = 1'b0, e_dma = 1'b0;

  function automatic string tag_of(int b);
    case (b)
      8: return "R2";  7: return "R3";  6: return "R4";  5: return "R5";
      4: return "R6";  3: return "R6";  2: return "R7";  1: return "R8";
      0: return "R9";  default: return "R11";
    endcase
  endfunction

  task automatic model();
    logic [8:0] s, c, nf;
    logic n_addr;
    e_irq = rst ? 1'b0 : |(ef & irq_mask);
    e_dma = rst ? 1'b0 : (ef[1] & tx_dma_en);
    if (rst || !en) begin
      ef = 9'h001; e_addr = 1'b0;
    end else begin
      s[8] = ev_misplaced & in_xfer & (is_master | ~addr_phase);
      s[7] = ev_cnt_done & cfg_reload & (is_master | cfg_sbc);
      s[6] = ev_cnt_done & is_master & ~cfg_reload & ~cfg_autoend;
      s[5] = ev_stop & (is_master ? stop_own : e_addr);
      s[4] = ev_nack; s[3] = ev_addr_match; s[2] = ev_rx_byte;
      s[1] = ev_tx_empty | (sts_wr & sts_data[1] & cfg_nostretch);
      s[0] = ev_tx_empty | (sts_wr & sts_data[0]);
      c = 9'h0;
      c[8] = clr_wr & clr_data[8]; c[7] = cnt_wr & (cnt_val != 0);
      c[6] = ctl_startstop_wr; c[5] = clr_wr & clr_data[5];
      c[4] = clr_wr & clr_data[4]; c[3] = clr_wr & clr_data[3];
      c[2] = rxd_rd; c[1] = txd_wr; c[0] = txd_wr;
      nf = s | (ef & ~c);
      n_addr = ev_stop ? 1'b0 : ((ev_addr_match & ~is_master) ? 1'b1 : e_addr);
      ef = nf; e_addr = n_addr;
    end
  endtask

  task automatic pulses_off();
    ev_misplaced = 0; ev_stop = 0; ev_nack = 0; ev_addr_match = 0;
    ev_rx_byte = 0; ev_tx_empty = 0; ev_cnt_done = 0; clr_wr = 0;
    clr_data = 0; txd_wr = 0; rxd_rd = 0; cnt_wr = 0; cnt_val = 0;
    ctl_startstop_wr = 0; sts_wr = 0; sts_data = 0;
  endtask

  // Drive at a negedge, let one posedge pass, compare at the next negedge
  task automatic step(string tag);
    logic [10:0] exp_st;
    model();
    @(negedge clk);
    exp_st = {2'b00, ef};
    nvec++;
    if (status !== exp_st || irq !== e_irq || tx_dma_req !== e_dma) begin
      string t;
      t = tag;
      if (tag == "") begin
        t = "R11";
        for (int b = 8; b >= 0; b--)
          if (status[b] !== exp_st[b]) begin t = tag_of(b); break; end
        if (status[10:9] !== 2'b00) t = "R1";
      end
      nbad++;
      $display("FAIL %s: status=%h irq=%b dma=%b expected status=%h irq=%b dma=%b",
               t, status, irq, tx_dma_req, exp_st, e_irq, e_dma);
    end
    pulses_off();
  endtask

  initial begin
    rst = 1; en = 0; is_master = 0; cfg_reload = 0; cfg_autoend = 0;
    cfg_nostretch = 0; cfg_sbc = 0; in_xfer = 0; addr_phase = 0; stop_own = 0;
    irq_mask = 0; tx_dma_en = 0;
    pulses_off();
    @(negedge clk);
    step("R1");                         // reset state 001
    rst = 0;
    ev_rx_byte = 1; ev_nack = 1; txd_wr = 1; ev_addr_match = 1;
    step("R1");                         // disabled: events ignored
    en = 1; step("R12");
    ev_rx_byte = 1; step("R7"); rxd_rd = 1; step("R7");
    in_xfer = 1; is_master = 1; ev_misplaced = 1; step("R2");
    clr_wr = 1; clr_data = 9'h100; step("R2");
    is_master = 0; addr_phase = 1; ev_misplaced = 1; step("R2");
    addr_phase = 0; ev_misplaced = 1; step("R2");
    clr_wr = 1; clr_data = 9'h100; step("R2");
    is_master = 1; cfg_reload = 1; ev_cnt_done = 1; step("R3");
    cnt_wr = 1; cnt_val = 0; step("R3");
    cnt_wr = 1; cnt_val = 5; step("R3");
    is_master = 0; ev_cnt_done = 1; step("R3");
    cfg_sbc = 1; ev_cnt_done = 1; step("R3");
    cnt_wr = 1; cnt_val = 1; step("R3");
    cfg_reload = 0; ev_cnt_done = 1; step("R4");
    is_master = 1; cfg_autoend = 1; ev_cnt_done = 1; step("R4");
    cfg_autoend = 0; ev_cnt_done = 1; step("R4");
    ctl_startstop_wr = 1; step("R4");
    is_master = 0; ev_stop = 1; step("R5");
    ev_addr_match = 1; step("R6");
    ev_stop = 1; step("R5");
    clr_wr = 1; clr_data = 9'h028; step("R5");
    ev_stop = 1; step("R5");
    is_master = 1; stop_own = 0; ev_stop = 1; step("R5");
    stop_own = 1; ev_stop = 1; step("R5");
    clr_wr = 1; clr_data = 9'h020; step("R5");
    ev_nack = 1; step("R6"); clr_wr = 1; clr_data = 9'h010; step("R6");
    sts_wr = 1; sts_data = 2'b10; step("R8");
    cfg_nostretch = 1; sts_wr = 1; sts_data = 2'b10; step("R8");
    txd_wr = 1; step("R9");
    sts_wr = 1; sts_data = 2'b01; step("R9");
    ev_tx_empty = 1; step("R8");
    ev_nack = 1; clr_wr = 1; clr_data = 9'h010; step("R10");
    ev_rx_byte = 1; rxd_rd = 1; step("R10");
    irq_mask = 9'h004; tx_dma_en = 1; step("R11");
    step("R11");
    rxd_rd = 1; step("R11"); step("R11");
    en = 0; step("R1"); en = 1; step("R1");
    // Pseudo-random sweep over all inputs
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] r, q;
      r = $urandom; q = $urandom;
      en = (r[3:0] != 0); is_master = r[4]; cfg_reload = r[5];
      cfg_autoend = r[6]; cfg_nostretch = r[7]; cfg_sbc = r[8];
      in_xfer = r[9]; addr_phase = r[10]; stop_own = r[11];
      ev_misplaced = r[12]; ev_stop = r[13] & r[14]; ev_nack = r[15];
      ev_addr_match = r[16]; ev_rx_byte = r[17]; ev_tx_empty = r[18];
      ev_cnt_done = r[19]; clr_wr = r[20]; clr_data = q[8:0];
      txd_wr = r[21]; rxd_rd = r[22]; cnt_wr = r[23];
      cnt_val = r[24] ? 8'd0 : q[16:9]; ctl_startstop_wr = r[25];
      sts_wr = r[26]; sts_data = q[18:17]; irq_mask = q[27:19];
      tx_dma_en = r[27];
      step("");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule